// File: doc/BRIEF.md
# GPIO Interrupt Routing Mux

This block sits between three GPIO controllers and an interrupt controller that has fewer inputs than there are GPIO interrupt lines. Controller 0 supplies 14 request lines, controller 1 supplies 24 and controller 2 supplies 32, which makes 70 in all. They are folded onto 41 outputs. Thirty-eight outputs are direct, with one source each. Three are shared, and each of those is the OR of one controller's demoted lines.

A 32-bit routing register holds one bit per contested direct output. Each bit settles a contest between two lines. One is a line of controller 0 or controller 1 (the "low side"). The other is the controller 2 line with the same index. The winner drives the direct output and the loser is demoted onto its own controller's shared output. Six lines of controller 1, its upper six, are wired to their own direct outputs and never pass through the selection. Software reaches the register over a simple single-cycle bus and can read back the current setting. Every output is registered, so a new routing setting never makes an output glitch.

When the outputs are numbered from interrupt 13 upward, direct output j is interrupt 13+j and shared output k is interrupt 51+k.

Top module: `gpio_irq_router`

## Requirements
- R1: During reset and on the first cycle after it, the routing register reads 0 at the control address, and every direct and shared output is 0.
- R2: A bus write with the address equal to the control address (default 0x54) loads the routing register with the write data at that clock edge. In any cycle, a read at the control address returns the register value combinationally.
- R3: A bus access to any other address returns read data of 0. A write to such an address leaves the routing register unchanged, which the next read at the control address shows.
- R4: For bits 0 to 13, bit j clear routes controller 0 line j to direct output j, and bit j set routes controller 2 line j to direct output j.
- R5: For bits 14 to 31, bit j clear routes controller 1 line j-14 to direct output j, and bit j set routes controller 2 line j to direct output j.
- R6: Direct outputs 32 to 37 carry controller 1 lines 18 to 23 in that order, whatever the routing register holds.
- R7: Shared output 0 is the OR of the controller 0 lines i whose bit i is set. Shared output 1 is the OR of the controller 1 lines i (0 to 17) whose bit i+14 is set. Controller 1 lines 18 to 23 never feed shared output 1.
- R8: Shared output 2 is the OR of the controller 2 lines i whose bit i is clear.
- R9: The outputs are registered. An output at clock edge t reflects the inputs sampled at edge t-1 and the routing register value held before edge t-1, so a register write first changes the routing on the edge after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| gpio0_irq | input | 14 | Controller 0 interrupt requests |
| gpio1_irq | input | 24 | Controller 1 interrupt requests |
| gpio2_irq | input | 32 | Controller 2 interrupt requests |
| direct_irq | output | 38 | Direct outputs (interrupts 13 to 50) |
| shared_irq | output | 3 | Shared outputs, one per controller (interrupts 51 to 53) |

## Verification
The bench builds the block with its default values: 14 controller-0 pairs, 18 controller-1 pairs and 6 exclusive lines. These fill the 32-bit routing register completely, so the top bit 31 and the boundary between bits 13 and 14 are both exercised. The bypass lines sit directly above the last contested output. Walking-one register values and random input patterns drive every pairing both ways. Writes to neighbouring addresses check that no stray access alters the routing.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int unsigned N_PAIR0   = 14,
  parameter int unsigned N_PAIR1   = 18,
  parameter int unsigned N_EXCL    = 6,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_ADDR = 'h54,
  localparam int unsigned C0_W  = N_PAIR0,
  localparam int unsigned C1_W  = N_PAIR1 + N_EXCL,
  localparam int unsigned MUX_W = N_PAIR0 + N_PAIR1,
  localparam int unsigned C2_W  = MUX_W,
  localparam int unsigned DIR_W = MUX_W + N_EXCL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [C0_W-1:0]   gpio0_irq,
  input  logic [C1_W-1:0]   gpio1_irq,
  input  logic [C2_W-1:0]   gpio2_irq,
  output logic [DIR_W-1:0]  direct_irq,
  output logic [2:0]        shared_irq
);

  logic [MUX_W-1:0] sel_q;
  logic [MUX_W-1:0] low_side;
  logic [DIR_W-1:0] direct_d;
  logic [2:0]       shared_d;
  logic             hit;

  assign hit = (bus_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else if (bus_we && hit)
      sel_q <= bus_wdata[MUX_W-1:0];
  end

  assign bus_rdata = hit ? DATA_W'(sel_q) : '0;

  assign low_side = {gpio1_irq[N_PAIR1-1:0], gpio0_irq};

  assign direct_d = {gpio1_irq[C1_W-1:N_PAIR1],
                     (sel_q & gpio2_irq) | (~sel_q & low_side)};

  assign shared_d[0] = |(gpio0_irq & sel_q[N_PAIR0-1:0]);
  assign shared_d[1] = |(gpio1_irq[N_PAIR1-1:0] & sel_q[MUX_W-1:N_PAIR0]);
  assign shared_d[2] = |(gpio2_irq & ~sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      direct_irq <= '0;
      shared_irq <= '0;
    end else begin
      direct_irq <= direct_d;
      shared_irq <= shared_d;
    end
  end

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
  parameter int unsigned C0_W      = 14,
  parameter int unsigned C1_W      = 24,
  parameter int unsigned C2_W      = 32,
  parameter int unsigned MUX_W     = 32,
  parameter int unsigned DIR_W     = 38,
  parameter int unsigned N_EXCL    = 6,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_ADDR = 'h54
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [C0_W-1:0]   gpio0_irq,
  input logic [C1_W-1:0]   gpio1_irq,
  input logic [C2_W-1:0]   gpio2_irq,
  input logic [DIR_W-1:0]  direct_irq,
  input logic [2:0]        shared_irq,
  input logic [MUX_W-1:0]  sel_q
);

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(CTRL_ADDR)) |=> sel_q == $past(bus_wdata[MUX_W-1:0]));

  // R3
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != ADDR_W'(CTRL_ADDR)) |=> $stable(sel_q));

  // R3
  stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(CTRL_ADDR)) |-> bus_rdata == '0);

  // R6
  excl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> direct_irq[DIR_W-1:MUX_W] == $past(gpio1_irq[C1_W-1:C1_W-N_EXCL]));

  // R8
  shared2_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shared_irq[2] |-> $past(|gpio2_irq));

  // R7
  shared0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shared_irq[0] |-> $past(|gpio0_irq));

endmodule

bind gpio_irq_router gpio_irq_router_chk #(
  .C0_W(C0_W), .C1_W(C1_W), .C2_W(C2_W), .MUX_W(MUX_W), .DIR_W(DIR_W),
  .N_EXCL(N_EXCL), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio0_irq(gpio0_irq),
  .gpio1_irq(gpio1_irq), .gpio2_irq(gpio2_irq), .direct_irq(direct_irq),
  .shared_irq(shared_irq), .sel_q(sel_q)
);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam logic [7:0] CTRL = 8'h54;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [13:0] g0 = '0;
  logic [23:0] g1 = '0;
  logic [31:0] g2 = '0;
  logic [37:0] direct_irq;
  logic [2:0]  shared_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [31:0] m_sel;
  logic [37:0] m_dir;
  logic [2:0]  m_sh;

  always #2 clk = ~clk;

  gpio_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio0_irq(g0),
    .gpio1_irq(g1), .gpio2_irq(g2), .direct_irq(direct_irq),
    .shared_irq(shared_irq)
  );

  // Behavioural reference: outputs use the register value held before the edge (R9)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = '0; m_dir = '0; m_sh = '0;
    end else begin
      for (int j = 0; j < 32; j++) begin
        if (m_sel[j]) m_dir[j] = g2[j];
        else if (j < 14) m_dir[j] = g0[j];
        else m_dir[j] = g1[j-14];
      end
      for (int e = 0; e < 6; e++) m_dir[32+e] = g1[18+e];
      m_sh = '0;
      for (int i = 0; i < 14; i++) if (m_sel[i] && g0[i]) m_sh[0] = 1'b1;
      for (int i = 0; i < 18; i++) if (m_sel[i+14] && g1[i]) m_sh[1] = 1'b1;
      for (int i = 0; i < 32; i++) if (!m_sel[i] && g2[i]) m_sh[2] = 1'b1;
      if (bus_we && bus_addr == CTRL) m_sel = bus_wdata;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int j = 0; j < 38; j++) begin
        if (j < 14)      chk("R4 (R9 timing)", 64'(direct_irq[j]), 64'(m_dir[j]));
        else if (j < 32) chk("R5 (R9 timing)", 64'(direct_irq[j]), 64'(m_dir[j]));
        else             chk("R6", 64'(direct_irq[j]), 64'(m_dir[j]));
      end
      chk("R7 shared0", 64'(shared_irq[0]), 64'(m_sh[0]));
      chk("R7 shared1", 64'(shared_irq[1]), 64'(m_sh[1]));
      chk("R8 shared2", 64'(shared_irq[2]), 64'(m_sh[2]));
      if (bus_addr == CTRL) chk("R2 readback", 64'(bus_rdata), 64'(m_sel));
      else                  chk("R3 stray read", 64'(bus_rdata), 64'd0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_addr = CTRL;
  endtask

  task automatic rnd_inputs(input int n);
    for (int k = 0; k < n; k++) begin
      g0 = 14'($urandom); g1 = 24'($urandom); g2 = $urandom;
      step();
    end
  endtask

  initial begin
    bus_addr = CTRL;
    g0 = 14'h3fff; g1 = 24'hffffff; g2 = '1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 rdata in reset", 64'(bus_rdata), 64'd0);
    chk("R1 direct in reset", 64'(direct_irq), 64'd0);
    chk("R1 shared in reset", 64'(shared_irq), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    g0 = '0; g1 = '0; g2 = '0;
    @(negedge clk);
    chk("R1 rdata after reset", 64'(bus_rdata), 64'd0);
    #1;
    rnd_inputs(40);
    // R4 R5 R7: all low-side losers
    wr(CTRL, 32'hffff_ffff);
    rnd_inputs(40);
    // R2 walking one across every bit, including 13/14 boundary and bit 31
    for (int b = 0; b < 32; b++) begin
      wr(CTRL, 32'h1 << b);
      g0 = '0; g1 = '0; g2 = '0;
      if (b < 14) g0[b] = 1'b1; else g1[b-14] = 1'b1;
      step();
      g0 = '0; g1 = '0; g2 = 32'h1 << b;
      step();
      rnd_inputs(2);
    end
    // R3: stray writes next to the control address leave routing alone
    wr(CTRL, 32'h00a5_5a3c);
    wr(8'h50, 32'hffff_ffff);
    wr(8'h58, 32'h0);
    wr(8'h55, 32'h1234_5678);
    bus_addr = 8'h50; rnd_inputs(5);
    bus_addr = CTRL;  rnd_inputs(5);
    // R6: exclusive lines only, against both register extremes
    wr(CTRL, 32'h0);
    g0 = '0; g2 = '0; g1 = 24'hfc0000; step(); step();
    wr(CTRL, 32'hffff_ffff);
    g1 = 24'h540000; step(); step();
    // R8: all zero inputs
    g0 = '0; g1 = '0; g2 = '0; step(); step();
    // random register values with back-to-back writes
    for (int r = 0; r < 100; r++) begin
      wr(CTRL, $urandom);
      rnd_inputs(3);
    end
    step(); step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule